// File: doc/BRIEF.md
# Error-Ratio Clock Frequency Governor

This block chooses the operating frequency of a hashing core. The frequency is carried as a PLL multiplier `mult`. The output clock equals `mult` times a 48 MHz reference, divided by a build-time denominator. A denominator of 6 gives 8 MHz steps, 8 gives 6 MHz steps, and the default of 12 gives 4 MHz steps. After reset the governor sits at the multiplier that gives a nominal 200 MHz, which is 50 at the default denominator.

The governor uses measurement windows of programmable length. In each window it counts produced results (`hash_pulse`) and failed results (`err_pulse`). It then compares the error ratio against two limits, without using a divider:

- **Above 1%** (`errs*100 > total`): the current step is blacklisted and the multiplier drops by one.
- **Below 0.1%** (`errs*1000 < total`): the multiplier climbs by one, unless the next step is blacklisted or at the programmable ceiling. In that case the governor settles where it is.
- **In between:** it holds and measures again.

A blacklist is cleared once a retry timer has run for `retry_len` cycles after the most recent mark. Each multiplier change is handed to an external PLL controller with a request/acknowledge handshake. Counting then stays frozen until the PLL reports lock. Right after start-up the multiplier changes often. Once a neighbour step has failed, changes become rare.

The control is a four-state machine:

| State | Code | Leaves when | Goes to |
|---|---|---|---|
| WAIT_LOCK | 0 | `pll_locked` is seen high | MEASURE |
| MEASURE | 1 | the window completes | DECIDE |
| DECIDE | 2 | it has evaluated the ratio, in one cycle | RECONF if `mult` changed, otherwise back to MEASURE with a fresh window |
| RECONF | 3 | `pll_ack` arrives | WAIT_LOCK |

Top module: `freq_governor`

## Requirements
- R1: During and right after reset: `mult` = 50, `reconf_req` = 0, `settled` = 0, `valid_last` = 0 and `gov_state` = 0.
- R2: A window covers exactly `win_len` cycles spent in MEASURE. After the window, `valid_last` holds the count of results minus the count of errors from that window.
- R3: If `errs*100 > total`, the governor blacklists the current step. If `mult > mult_min`, it also lowers `mult` by one.
- R4: If `errs*1000 < total`, `mult < mult_max` and step `mult+1` is not blacklisted, the governor raises `mult` by one.
- R5: A ratio between the two limits leaves `mult` unchanged, raises no request and starts a new window.
- R6: A low ratio whose next step up is blacklisted holds `mult` and sets `settled` to 1.
- R7: Once `retry_len` cycles have passed since the last mark, all blacklist marks clear, and a previously failed step is tried again.
- R8: `mult` never moves above `mult_max` or below `mult_min`. A low ratio at the ceiling settles. A high ratio at the floor holds.
- R9: `reconf_req` rises only together with a change of `mult` and stays high until `pll_ack`. The governor then waits in WAIT_LOCK while `pll_locked` is low, and no pulses are counted there.
- R10: `gov_state` reports the state as 0 WAIT_LOCK, 1 MEASURE, 2 DECIDE, 3 RECONF.
- R11: `settled` clears whenever a high ratio is seen or `mult` steps up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_len | input | WIN_W | Measurement window length in cycles |
| retry_len | input | RETRY_W | Cycles after the last mark until the blacklist clears |
| mult_min | input | MULT_W | Lowest allowed multiplier |
| mult_max | input | MULT_W | Highest allowed multiplier |
| hash_pulse | input | 1 | One result produced |
| err_pulse | input | 1 | One result failed verification |
| pll_ack | input | 1 | PLL controller accepted the request |
| pll_locked | input | 1 | PLL lock indication |
| mult | output | MULT_W | Current PLL multiplier |
| reconf_req | output | 1 | Reconfigure request |
| gov_state | output | 2 | State code |
| settled | output | 1 | Governor has settled at a step |
| valid_last | output | CNT_W | Valid results in the last window |

## Verification
The bound checker watches, on every cycle, that:
- each multiplier change is a single step that stays inside the limits;
- the multiplier changes only on leaving DECIDE;
- a request rises only with a change and is held until acknowledged;
- the governor stays in WAIT_LOCK while lock is low.

The bench's scenarios are needed for the rest, which depends on the window contents:
- the decision reached for a given error count;
- the blacklist and settling behaviour;
- the retry expiry;
- the exact valid count;
- that pulses arriving outside MEASURE are ignored.

// File: rtl/freq_gov_pkg.sv
package freq_gov_pkg;

    typedef enum logic [1:0] {
        ST_WAIT_LOCK = 2'd0,
        ST_MEASURE   = 2'd1,
        ST_DECIDE    = 2'd2,
        ST_RECONF    = 2'd3
    } gov_state_t;

    typedef enum logic [1:0] {
        RATIO_MID  = 2'd0,
        RATIO_LOW  = 2'd1,
        RATIO_HIGH = 2'd2
    } ratio_class_t;

endpackage

// File: rtl/freq_gov_window.sv
module freq_gov_window #(
    parameter int CNT_W = 16,
    parameter int WIN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [WIN_W-1:0] win_len,
    input  logic             hash_pulse,
    input  logic             err_pulse,
    output logic [CNT_W-1:0] total,
    output logic [CNT_W-1:0] errs,
    output logic             win_done
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [WIN_W-1:0] win_cnt;
    logic [1:0]       pulse;
    logic [CNT_W-1:0] cnt [2];

    assign pulse = {err_pulse, hash_pulse};

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            win_cnt <= '0;
        end else begin
            win_cnt <= win_cnt + 1'b1;
        end
    end

    // Two saturating event counters, one per pulse input.
    for (genvar g = 0; g < 2; g++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (!rst_n || !run) begin
                cnt[g] <= '0;
            end else if (pulse[g] && cnt[g] != CNT_MAX) begin
                cnt[g] <= cnt[g] + 1'b1;
            end
        end
    end

    assign total    = cnt[0];
    assign errs     = cnt[1];
    assign win_done = run && (({1'b0, win_cnt} + 1'b1) >= {1'b0, win_len});

endmodule

// File: rtl/freq_gov_ratio.sv
module freq_gov_ratio
    import freq_gov_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] total,
    input  logic [CNT_W-1:0] errs,
    output ratio_class_t     ratio_class,
    output logic [CNT_W-1:0] valid
);
    localparam int PW = CNT_W + 10;

    logic [PW-1:0] err_x100;
    logic [PW-1:0] err_x1000;
    logic [PW-1:0] total_ext;

    always_comb begin
        total_ext = PW'(total);
        err_x100  = PW'(errs) * PW'(100);
        err_x1000 = PW'(errs) * PW'(1000);
        if (err_x100 > total_ext) begin
            ratio_class = RATIO_HIGH;
        end else if (err_x1000 < total_ext) begin
            ratio_class = RATIO_LOW;
        end else begin
            ratio_class = RATIO_MID;
        end
        valid = (total >= errs) ? (total - errs) : '0;
    end

endmodule

// File: rtl/freq_gov_blacklist.sv
module freq_gov_blacklist #(
    parameter int MULT_W  = 8,
    parameter int RETRY_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mark,
    input  logic [MULT_W-1:0]  mark_idx,
    input  logic [MULT_W-1:0]  query_idx,
    input  logic [RETRY_W-1:0] retry_len,
    output logic               query_bad
);
    localparam int NSTEP = 1 << MULT_W;

    logic [NSTEP-1:0]   bad;
    logic [RETRY_W-1:0] timer;
    logic               armed;
    logic               expire;

    assign expire = armed && !mark && (timer >= retry_len);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            timer <= '0;
        end else if (mark) begin
            armed <= 1'b1;
            timer <= '0;
        end else if (expire) begin
            armed <= 1'b0;
            timer <= '0;
        end else if (armed) begin
            timer <= timer + 1'b1;
        end
    end

    for (genvar i = 0; i < NSTEP; i++) begin : g_step
        always_ff @(posedge clk) begin
            if (!rst_n || expire) begin
                bad[i] <= 1'b0;
            end else if (mark && mark_idx == MULT_W'(i)) begin
                bad[i] <= 1'b1;
            end
        end
    end

    assign query_bad = bad[query_idx];

endmodule

// File: rtl/freq_governor.sv
module freq_governor
    import freq_gov_pkg::*;
#(
    parameter int MULT_W  = 8,
    parameter int REF_MHZ = 48,
    parameter int DENOM   = 12,
    parameter int NOM_MHZ = 200,
    parameter int CNT_W   = 16,
    parameter int WIN_W   = 16,
    parameter int RETRY_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WIN_W-1:0]   win_len,
    input  logic [RETRY_W-1:0] retry_len,
    input  logic [MULT_W-1:0]  mult_min,
    input  logic [MULT_W-1:0]  mult_max,
    input  logic               hash_pulse,
    input  logic               err_pulse,
    input  logic               pll_ack,
    input  logic               pll_locked,
    output logic [MULT_W-1:0]  mult,
    output logic               reconf_req,
    output logic [1:0]         gov_state,
    output logic               settled,
    output logic [CNT_W-1:0]   valid_last
);
    localparam logic [MULT_W-1:0] NOM_MULT = MULT_W'((NOM_MHZ * DENOM) / REF_MHZ);

    gov_state_t        state, state_nxt;
    ratio_class_t      ratio_class;
    logic [CNT_W-1:0]  total, errs, valid;
    logic              win_done;
    logic              up_bad;
    logic              up_ok, down_ok;
    logic              mark_bad;
    logic [MULT_W-1:0] mult_up;
    logic [MULT_W-1:0] mult_nxt;
    logic              settled_nxt;

    freq_gov_window #(.CNT_W(CNT_W), .WIN_W(WIN_W)) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (state == ST_MEASURE),
        .win_len    (win_len),
        .hash_pulse (hash_pulse),
        .err_pulse  (err_pulse),
        .total      (total),
        .errs       (errs),
        .win_done   (win_done)
    );

    freq_gov_ratio #(.CNT_W(CNT_W)) u_ratio (
        .total       (total),
        .errs        (errs),
        .ratio_class (ratio_class),
        .valid       (valid)
    );

    freq_gov_blacklist #(.MULT_W(MULT_W), .RETRY_W(RETRY_W)) u_black (
        .clk       (clk),
        .rst_n     (rst_n),
        .mark      (mark_bad),
        .mark_idx  (mult),
        .query_idx (mult_up),
        .retry_len (retry_len),
        .query_bad (up_bad)
    );

    assign mult_up  = mult + 1'b1;
    assign up_ok    = (mult < mult_max) && !up_bad;
    assign down_ok  = (mult > mult_min);
    assign mark_bad = (state == ST_DECIDE) && (ratio_class == RATIO_HIGH);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_WAIT_LOCK;
        end else begin
            state <= state_nxt;
        end
    end

    // Next state and decision
    always_comb begin
        state_nxt   = state;
        mult_nxt    = mult;
        settled_nxt = settled;
        unique case (state)
            ST_WAIT_LOCK: begin
                if (pll_locked) state_nxt = ST_MEASURE;
            end
            ST_MEASURE: begin
                if (win_done) state_nxt = ST_DECIDE;
            end
            ST_DECIDE: begin
                state_nxt = ST_MEASURE;
                unique case (ratio_class)
                    RATIO_HIGH: begin
                        settled_nxt = 1'b0;
                        if (down_ok) begin
                            mult_nxt  = mult - 1'b1;
                            state_nxt = ST_RECONF;
                        end
                    end
                    RATIO_LOW: begin
                        if (up_ok) begin
                            mult_nxt    = mult_up;
                            settled_nxt = 1'b0;
                            state_nxt   = ST_RECONF;
                        end else begin
                            settled_nxt = 1'b1;
                        end
                    end
                    default: begin
                        state_nxt = ST_MEASURE;
                    end
                endcase
            end
            ST_RECONF: begin
                if (pll_ack) state_nxt = ST_WAIT_LOCK;
            end
            default: state_nxt = ST_WAIT_LOCK;
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mult       <= NOM_MULT;
            settled    <= 1'b0;
            valid_last <= '0;
        end else begin
            mult    <= mult_nxt;
            settled <= settled_nxt;
            if (state == ST_DECIDE) valid_last <= valid;
        end
    end

    assign reconf_req = (state == ST_RECONF);
    assign gov_state  = state;

endmodule

// File: rtl/freq_governor_chk.sv
module freq_governor_chk #(
    parameter int MULT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [MULT_W-1:0] mult,
    input logic [MULT_W-1:0] mult_min,
    input logic [MULT_W-1:0] mult_max,
    input logic              reconf_req,
    input logic              pll_ack,
    input logic              pll_locked,
    input logic [1:0]        gov_state
);
    // R3 / R4: every change is one step
    p_one_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mult != $past(mult)) |-> ((mult == $past(mult) + 1'b1) || (mult + 1'b1 == $past(mult))));

    // R8: a new multiplier stays within limits
    p_clamp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mult != $past(mult)) |-> (mult >= mult_min && mult <= mult_max));

    // R9: request rises only together with a change
    p_req_on_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reconf_req) |-> (mult != $past(mult)));

    // R9: request held until acknowledged
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reconf_req && !pll_ack) |=> reconf_req);

    // R9: no counting state while lock is low
    p_lock_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (gov_state == 2'd0 && !pll_locked) |=> (gov_state == 2'd0));

    // R10: multiplier only moves on leaving the decide state
    p_mult_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (gov_state != 2'd2) |=> $stable(mult));

endmodule

bind freq_governor freq_governor_chk #(.MULT_W(MULT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mult       (mult),
    .mult_min   (mult_min),
    .mult_max   (mult_max),
    .reconf_req (reconf_req),
    .pll_ack    (pll_ack),
    .pll_locked (pll_locked),
    .gov_state  (gov_state)
);

// File: tb/tb_freq_governor.sv
module tb_freq_governor;
    localparam int MULT_W  = 8;
    localparam int CNT_W   = 16;
    localparam int WIN_W   = 16;
    localparam int RETRY_W = 24;
    localparam int W       = 200;

    logic               clk = 1'b0;
    logic               rst_n;
    logic [WIN_W-1:0]   win_len;
    logic [RETRY_W-1:0] retry_len;
    logic [MULT_W-1:0]  mult_min, mult_max;
    logic               hash_pulse, err_pulse, pll_ack, pll_locked;
    logic [MULT_W-1:0]  mult;
    logic               reconf_req;
    logic [1:0]         gov_state;
    logic               settled;
    logic [CNT_W-1:0]   valid_last;

    int n_checks = 0;
    int n_fail   = 0;

    int m_mult;
    bit m_settled;
    bit m_bad [256];

    always #10 clk = ~clk;

    freq_governor dut (
        .clk(clk), .rst_n(rst_n), .win_len(win_len), .retry_len(retry_len),
        .mult_min(mult_min), .mult_max(mult_max), .hash_pulse(hash_pulse),
        .err_pulse(err_pulse), .pll_ack(pll_ack), .pll_locked(pll_locked),
        .mult(mult), .reconf_req(reconf_req), .gov_state(gov_state),
        .settled(settled), .valid_last(valid_last)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic handshake();
        repeat (3) @(negedge clk);
        chk("R9", int'(reconf_req), 1);
        pll_ack    = 1'b1;
        pll_locked = 1'b0;
        @(negedge clk);
        pll_ack = 1'b0;
        repeat (5) @(negedge clk);
        chk("R9", int'(gov_state), 0);
        chk("R9", int'(reconf_req), 0);
        pll_locked = 1'b1;
        @(negedge clk);
        chk("R9", int'(gov_state), 1);
    endtask

    task automatic window(input int k, input string tag);
        bit high, low, changed;
        while (gov_state != 2'd1) @(negedge clk);
        for (int i = 0; i < W; i++) begin
            hash_pulse = 1'b1;
            err_pulse  = (i < k);
            @(negedge clk);
        end
        hash_pulse = 1'b1;
        err_pulse  = 1'b1;
        chk("R10", int'(gov_state), 2);
        @(negedge clk);
        high    = (k * 100) > W;
        low     = (k * 1000) < W;
        changed = 1'b0;
        if (high) begin
            m_bad[m_mult] = 1'b1;
            m_settled     = 1'b0;
            if (m_mult > int'(mult_min)) begin
                m_mult--;
                changed = 1'b1;
            end
        end else if (low) begin
            if (m_mult < int'(mult_max) && !m_bad[m_mult + 1]) begin
                m_mult++;
                changed   = 1'b1;
                m_settled = 1'b0;
            end else begin
                m_settled = 1'b1;
            end
        end
        chk(tag, int'(mult), m_mult);
        chk("R9", int'(reconf_req), int'(changed));
        chk("R11", int'(settled), int'(m_settled));
        chk("R2", int'(valid_last), W - k);
        chk("R10", int'(gov_state), changed ? 3 : 1);
        if (changed) handshake();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n      = 1'b0;
        win_len    = WIN_W'(W);
        retry_len  = {RETRY_W{1'b1}};
        mult_min   = 8'd40;
        mult_max   = 8'd60;
        hash_pulse = 1'b0;
        err_pulse  = 1'b0;
        pll_ack    = 1'b0;
        pll_locked = 1'b1;
        m_mult     = 50;
        m_settled  = 1'b0;
        foreach (m_bad[i]) m_bad[i] = 1'b0;
        repeat (5) @(negedge clk);
        chk("R1", int'(mult), 50);
        chk("R1", int'(reconf_req), 0);
        chk("R1", int'(settled), 0);
        chk("R1", int'(valid_last), 0);
        chk("R10", int'(gov_state), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", int'(gov_state), 1);

        window(1, "R5");   // mid ratio: hold
        window(0, "R4");   // low: 50 -> 51
        window(3, "R3");   // high: 51 -> 50, mark 51
        window(0, "R6");   // low but 51 bad: settle at 50

        // Blacklist expiry
        retry_len = RETRY_W'(50);
        window(1, "R5");
        foreach (m_bad[i]) m_bad[i] = 1'b0;
        window(0, "R7");   // 51 retried
        retry_len = {RETRY_W{1'b1}};

        // Clamping
        mult_max = 8'd52;
        window(0, "R8");   // 51 -> 52
        window(0, "R8");   // at ceiling: settle
        mult_min = 8'd52;
        window(5, "R8");   // at floor: hold
        mult_min = 8'd40;
        mult_max = 8'd60;

        for (int n = 0; n < 100; n++) begin
            int sel;
            int k;
            sel = int'($urandom_range(0, 5));
            case (sel)
                0, 1: k = 0;
                2:    k = 1;
                3:    k = 2;
                4:    k = 3;
                default: k = 6;
            endcase
            window(k, "R2");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule